// File: doc/BRIEF.md
# Interrupt Control and Status Register

This block is the interrupt front end of a small 8-bit microcontroller. It holds one byte-wide control/status register. The register has a master enable, an enable for each of four sources, and sticky flags for three of them. It captures a timer overflow strobe, a rising edge on an external interrupt pin, and any change on a four-pin port group. A fourth source, the EEPROM write-complete strobe, is held in an internal latch that is not visible in the register.

When the master enable and at least one enabled pending source are both set, the block raises an interrupt request. It also drives the fixed handler address to the CPU. Software reaches the register through a simple byte port with address, write data, write enable and combinational read data. It sets the enables and clears the flags by writing the whole byte. When the CPU acknowledges an interrupt, the master enable drops in hardware, so the handler is not re-entered.

Top module: `irq_ctl_unit`

## Requirements
- R1: After reset the register reads 0x00 and `irq_req` is 0.
- R2: The register sits at address 0x0B. A write there loads all eight bits, so writing 0x90 leaves only bits 7 and 4 set. Reads at any other address return 0x00, and writes to other addresses change nothing. Bit layout, from bit 7 down to bit 0: master enable, EEPROM enable, timer enable, pin enable, port-change enable, timer flag, pin flag, port-change flag.
- R3: While bit 7 is 0, `irq_req` is 0 whatever the other bits and the EEPROM latch hold.
- R4: A one-cycle `tmr_ovf` pulse sets bit 2 at the next clock edge. Bit 2 then stays set until software writes it to 0.
- R5: A rising edge on `ext_pin` sets bit 1 at the third clock edge after the pin rises. Holding the pin high does not set the flag again, and a falling edge does not set it.
- R6: A change in either direction on any bit of `port_hi` sets bit 0 at the third clock edge after the change.
- R7: `irq_req` = bit7 AND ((bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0) OR (bit6 AND EEPROM latch)).
- R8: The EEPROM latch is set by `ee_done` and cleared by `ee_clr`. If both arrive in the same cycle, set wins. The latch never appears in the read data.
- R9: `irq_ack` clears bit 7 at the next edge, even when a register write in the same cycle sets bit 7. The other bits of that write still load.
- R10: If a flag event arrives in the same cycle as a software write of 0 to that flag, the flag ends up set.
- R11: `irq_vector` always equals 0x004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data (combinational) |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ee_done | input | 1 | EEPROM write-complete pulse |
| ee_clr | input | 1 | Clears the EEPROM pending latch |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_hi | input | 4 | Asynchronous port pins watched for change |
| irq_ack | input | 1 | CPU interrupt acknowledge |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vector | output | 13 | Handler program address |

## Verification
The bench writes all 256 register values, with the EEPROM latch both clear and set, and compares `irq_req` against the gating equation computed in the bench. This sweep catches any mis-paired enable and flag, and any leak past the master enable.

The edge detectors are timed to the exact cycle. A synchronizer with one stage too many or too few shifts the flag by a clock. A level detector sets the pin flag again while the pin is held high, or on the falling edge.

Each port bit is toggled both up and down, which exposes a detector that only watches some bits or one direction.

The same-cycle races are all driven: a flag event against a write of 0, an acknowledge against a write of 1 to the master enable, and EEPROM set against clear. Each race is checked for the winner the requirements name.

// File: rtl/irq_ctl_unit.sv
module irq_ctl_unit #(
  parameter int                  ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]   CTL_ADDR = 'h0B,
  parameter int                  PC_W     = 13,
  parameter logic [PC_W-1:0]     VECTOR   = 'h004,
  parameter int                  CHG_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_we,
  output logic [7:0]        reg_rdata,
  input  logic              tmr_ovf,
  input  logic              ee_done,
  input  logic              ee_clr,
  input  logic              ext_pin,
  input  logic [CHG_W-1:0]  port_hi,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [PC_W-1:0]   irq_vector
);

  localparam int B_GIE = 7, B_EEE = 6, B_TME = 5, B_PNE = 4, B_CHE = 3;
  localparam int F_TMR = 2, F_PIN = 1, F_CHG = 0;

  logic [7:0]       ctl, ctl_d;
  logic             ee_pend;
  logic [2:0]       pin_sh;
  logic [CHG_W-1:0] chg_s1, chg_s2, chg_snap;

  wire wr_hit   = reg_we && (reg_addr == CTL_ADDR);
  wire pin_rise = pin_sh[1] & ~pin_sh[2];
  wire port_chg = |(chg_s2 ^ chg_snap);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_sh   <= '0;
      chg_s1   <= '0;
      chg_s2   <= '0;
      chg_snap <= '0;
    end else begin
      pin_sh   <= {pin_sh[1:0], ext_pin};
      chg_s1   <= port_hi;
      chg_s2   <= chg_s1;
      chg_snap <= chg_s2;
    end

  always_comb begin
    ctl_d = ctl;
    if (wr_hit)   ctl_d = reg_wdata;
    if (irq_ack)  ctl_d[B_GIE] = 1'b0;
    if (tmr_ovf)  ctl_d[F_TMR] = 1'b1;
    if (pin_rise) ctl_d[F_PIN] = 1'b1;
    if (port_chg) ctl_d[F_CHG] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl     <= '0;
      ee_pend <= 1'b0;
    end else begin
      ctl     <= ctl_d;
      ee_pend <= ee_done | (ee_pend & ~ee_clr);
    end

  assign reg_rdata  = (reg_addr == CTL_ADDR) ? ctl : 8'h00;
  assign irq_vector = VECTOR;
  assign irq_req    = ctl[B_GIE] & ((ctl[B_TME] & ctl[F_TMR]) |
                                    (ctl[B_PNE] & ctl[F_PIN]) |
                                    (ctl[B_CHE] & ctl[F_CHG]) |
                                    (ctl[B_EEE] & ee_pend));

  assert_gie_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[B_GIE] |-> !irq_req);
  assert_tmr_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> ctl[F_TMR]);
  assert_tmr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[F_TMR] && !(wr_hit && !reg_wdata[F_TMR])) |=> ctl[F_TMR]);
  assert_port_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    port_chg |=> ctl[F_CHG]);
  assert_ee_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ee_done |=> ee_pend);
  assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !ctl[B_GIE]);
  assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_rise && wr_hit && !reg_wdata[F_PIN]) |=> ctl[F_PIN]);

endmodule

// File: tb/irq_ctl_unit_test.sv
module irq_ctl_unit_test;
  logic clk = 0, rst_n = 0;
  logic [7:0] reg_addr = 8'h0B, reg_wdata = 0, reg_rdata;
  logic reg_we = 0, tmr_ovf = 0, ee_done = 0, ee_clr = 0, ext_pin = 0, irq_ack = 0;
  logic [3:0] port_hi = 0;
  logic irq_req;
  logic [12:0] irq_vector;
  int compared = 0, mismatched = 0;
  bit done = 0;

  irq_ctl_unit uut (.clk, .rst_n, .reg_addr, .reg_wdata, .reg_we, .reg_rdata,
    .tmr_ovf, .ee_done, .ee_clr, .ext_pin, .port_hi, .irq_ack, .irq_req, .irq_vector);

  always #10 clk = ~clk;

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic chk(string rq, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    step();
    reg_we = 0; reg_addr = 8'h0B;
    #1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    step(2); rst_n = 1; step();
    chk("R1 reset reg", reg_rdata, 8'h00);
    chk("R1 reset req", irq_req, 0);
    chk("R11 vector", irq_vector, 13'h004);

    // R2, R3, R7: full sweep of register values with EEPROM latch off and on
    for (int ee = 0; ee < 2; ee++) begin
      if (ee == 1) begin ee_done = 1; step(); ee_done = 0; end
      for (int v = 0; v < 256; v++) begin
        logic [7:0] b;
        logic e;
        b = v[7:0];
        e = b[7] & ((b[5] & b[2]) | (b[4] & b[1]) | (b[3] & b[0]) | (b[6] & ee[0]));
        wr(8'h0B, b);
        chk("R2 readback", reg_rdata, b);
        chk(b[7] ? "R7 request" : "R3 gated", irq_req, e);
      end
      ee_clr = 1; step(); ee_clr = 0;
    end

    wr(8'h0B, 8'h90);
    chk("R2 write 0x90", reg_rdata, 8'h90);
    wr(8'h0A, 8'hFF);
    chk("R2 other addr write ignored", reg_rdata, 8'h90);
    reg_addr = 8'h0A; #1;
    chk("R2 other addr reads zero", reg_rdata, 8'h00);
    reg_addr = 8'h0B; #1;

    // R4 timer flag
    wr(8'h0B, 8'h00);
    tmr_ovf = 1; step(); tmr_ovf = 0;
    chk("R4 timer flag set", reg_rdata, 8'h04);
    step(5);
    chk("R4 timer flag sticky", reg_rdata, 8'h04);
    wr(8'h0B, 8'h00);
    chk("R4 timer flag cleared", reg_rdata, 8'h00);

    // R10 event beats write of zero
    reg_wdata = 8'h00; reg_we = 1; tmr_ovf = 1; step(); reg_we = 0; tmr_ovf = 0;
    chk("R10 timer event wins", reg_rdata, 8'h04);
    wr(8'h0B, 8'h00);

    // R5 external pin rising edge
    ext_pin = 1; step(2);
    chk("R5 pin flag not before third edge", reg_rdata, 8'h00);
    step();
    chk("R5 pin flag at third edge", reg_rdata, 8'h02);
    wr(8'h0B, 8'h00); step(4);
    chk("R5 held high no retrigger", reg_rdata, 8'h00);
    ext_pin = 0; step(4);
    chk("R5 falling edge ignored", reg_rdata, 8'h00);
    ext_pin = 1; step(2);
    reg_wdata = 8'h00; reg_we = 1; step(); reg_we = 0;
    chk("R10 pin event wins over write", reg_rdata, 8'h02);
    ext_pin = 0; wr(8'h0B, 8'h00); step(3);

    // R6 port change, each bit both directions
    for (int i = 0; i < 4; i++)
      for (int d = 0; d < 2; d++) begin
        port_hi[i] = ~port_hi[i]; step(2);
        chk("R6 port flag not before third edge", reg_rdata, 8'h00);
        step();
        chk("R6 port flag at third edge", reg_rdata, 8'h01);
        wr(8'h0B, 8'h00);
        chk("R6 port flag cleared", reg_rdata, 8'h00);
      end

    // R9 acknowledge
    wr(8'h0B, 8'h92);
    chk("R9 request before ack", irq_req, 1);
    irq_ack = 1; step(); irq_ack = 0;
    chk("R9 ack clears master", reg_rdata, 8'h12);
    chk("R9 ack drops request", irq_req, 0);
    reg_wdata = 8'hA0; reg_we = 1; irq_ack = 1; step(); reg_we = 0; irq_ack = 0;
    chk("R9 ack beats write", reg_rdata, 8'h20);

    // R8 EEPROM latch
    wr(8'h0B, 8'hC0);
    chk("R8 no pending no req", irq_req, 0);
    ee_done = 1; step(); ee_done = 0;
    chk("R8 latch raises req", irq_req, 1);
    chk("R8 latch invisible", reg_rdata, 8'hC0);
    ee_clr = 1; step(); ee_clr = 0;
    chk("R8 clear drops req", irq_req, 0);
    ee_done = 1; ee_clr = 1; step(); ee_done = 0; ee_clr = 0;
    chk("R8 set wins over clear", irq_req, 1);
    chk("R11 vector steady", irq_vector, 13'h004);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule